// File: doc/BRIEF.md
# Indexed Pixel Pipeline with Cursor Overlay

This block turns an 8-bit-per-pixel indexed frame buffer into a stream of 24-bit RGB pixels. A start-of-frame strobe launches a raster walk over `width_i` by `height_i` positions. Each position reads one byte from an external synchronous frame memory. The walk begins at the `top_i` byte offset and moves linearly, so the next row follows directly after `width_i` bytes. The byte indexes a 256-entry colour table. A 64x64 hardware cursor can sit on top of the image. Inside the cursor window, a 2-bit code from a packed cursor bitmap either lets the image show through or picks one of three cursor colours.

The downstream consumer paces the stream with `ready_i`. Every stage advances only when `ready_i` is high. The output carries a valid flag and markers for end of line and end of frame. Forced blanking and unsupported pixel depths both produce black pixels, and the stream timing stays the same. An interrupt level rises once the last pixel of a frame has been accepted, and it stays high until it is cleared. The colour table, the cursor colours and the cursor bitmap are loaded through simple write ports. The geometry and control values are plain static inputs.

Top module: `cursor_pixel_pipe`

## Requirements
- R1: After an accepted start of frame, positions are issued in raster order, one per cycle with `ready_i` high, with `fb_rd_o` high and `fb_addr_o` equal to (`top_i` + y*`width_i` + x) modulo 2^23. No read is issued while `ready_i` is low.
- R2: A position issued at a clock edge appears on the pixel outputs after the next edge at which `ready_i` is high. With `ready_i` high throughout, the first pixel is visible two edges after the edge that samples `sof_i`. While `ready_i` is low, all pixel outputs hold.
- R3: `pix_eol_o` marks the last pixel of every row (x = width-1). `pix_eof_o` marks only the last pixel of the frame, and it always comes together with `pix_eol_o`.
- R4: Outside the cursor, the pixel colour is the colour-table entry selected by the frame-memory byte. Entries are written through `pal_we_i`/`pal_addr_i`/`pal_data_i`, with the data laid out as {red[23:16], green[15:8], blue[7:0]}.
- R5: The cursor origin is X = `cur_pos_i`[23:12] and Y = `cur_pos_i`[11:0]. A pixel is in the cursor window when X <= x < X+64 and Y <= y < Y+64.
- R6: Inside the window, with dx = x-X and dy = y-Y, the code is bits [2*(dx mod 8)+1 : 2*(dx mod 8)] of bitmap word dy*8 + dx/8. Code 0 shows the image pixel. Codes 1, 2 and 3 show cursor colours 0, 1 and 2 (`cpal_sel_i` values 0 to 2; a write with select 3 is dropped).
- R7: With `cur_off_i` high, no pixel is in the cursor window.
- R8: With `blank_i` high, every valid pixel is black (0) and the stream timing is unchanged.
- R9: Only `depth_i` = 3 (8 bits per pixel) is rendered. Any other code gives black pixels with unchanged timing.
- R10: A start of frame with `width_i` or `height_i` equal to zero is ignored: no read is issued and no pixel is output.
- R11: `irq_o` rises on the edge that accepts the end-of-frame pixel and stays high until `irq_clr_i`. If both happen on the same edge, the set wins.
- R12: Whenever `pix_valid_o` is low, `pix_rgb_o` is 0. After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame strobe |
| ready_i | input | 1 | Downstream ready; advances the whole pipeline |
| width_i | input | 12 | Active pixels per line |
| height_i | input | 12 | Active lines per frame |
| top_i | input | 23 | Byte offset of the first pixel in frame memory |
| cur_pos_i | input | 24 | Cursor origin, X in [23:12], Y in [11:0] |
| cur_off_i | input | 1 | Cursor disable |
| blank_i | input | 1 | Force black output |
| depth_i | input | 3 | Pixel depth code; 3 means 8 bits per pixel |
| pal_we_i | input | 1 | Colour-table write enable |
| pal_addr_i | input | 8 | Colour-table entry |
| pal_data_i | input | 24 | Colour-table RGB value |
| cpal_we_i | input | 1 | Cursor-colour write enable |
| cpal_sel_i | input | 2 | Cursor colour select, 0 to 2 |
| cpal_data_i | input | 24 | Cursor colour RGB value |
| pat_we_i | input | 1 | Cursor-bitmap write enable |
| pat_addr_i | input | 9 | Cursor-bitmap word index |
| pat_data_i | input | 16 | Cursor-bitmap word, 8 pixels of 2 bits |
| irq_clr_i | input | 1 | Clears the interrupt level |
| fb_data_i | input | 8 | Frame-memory read data, one cycle after the read |
| fb_rd_o | output | 1 | Frame-memory read enable |
| fb_addr_o | output | 23 | Frame-memory byte address |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_rgb_o | output | 24 | Output pixel colour |
| pix_eol_o | output | 1 | Last pixel of a line |
| pix_eof_o | output | 1 | Last pixel of the frame |
| irq_o | output | 1 | End-of-frame interrupt level |

## Verification
A pixel is accepted downstream at an edge where `pix_valid_o` and `ready_i` are both high. The bench samples at the falling edge before that edge and checks the pixel against the colour it computes from the raster index. The first pixel of an unstalled frame must appear two edges after the edge that samples `sof_i`, and the bench checks the falling edges at one, two and three edges out. Stability under stall is checked one cycle later, at every falling edge that follows a cycle with a valid pixel and `ready_i` low. The interrupt level is sampled two cycles after the last accepted pixel, and again one cycle after the clear pulse.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
  typedef logic [23:0] rgb_t;

  localparam logic [2:0] DEPTH_8BPP = 3'd3;

  typedef struct packed {
    logic       valid;
    logic       eol;
    logic       eof;
    logic [1:0] ccode;
  } stage_t;
endpackage

// File: rtl/cpp_raster_scan.sv
module cpp_raster_scan #(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 23
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sof_i,
  input  logic               ready_i,
  input  logic [COORD_W-1:0] width_i,
  input  logic [COORD_W-1:0] height_i,
  input  logic [ADDR_W-1:0]  top_i,
  output logic               issue_o,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o,
  output logic               eol_o,
  output logic               eof_o,
  output logic [ADDR_W-1:0]  addr_o
);
  logic               run_q;
  logic [COORD_W-1:0] x_q, y_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               last_x, last_y, start;

  assign last_x  = (x_q == width_i - COORD_W'(1));
  assign last_y  = (y_q == height_i - COORD_W'(1));
  assign start   = sof_i && (width_i != '0) && (height_i != '0);
  assign issue_o = run_q && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
      addr_q <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      x_q    <= '0;
      y_q    <= '0;
      addr_q <= top_i;
    end else if (issue_o) begin
      addr_q <= addr_q + ADDR_W'(1);
      if (last_x) begin
        x_q <= '0;
        if (last_y) run_q <= 1'b0;
        else        y_q   <= y_q + COORD_W'(1);
      end else begin
        x_q <= x_q + COORD_W'(1);
      end
    end
  end

  assign x_o    = x_q;
  assign y_o    = y_q;
  assign eol_o  = last_x;
  assign eof_o  = last_x && last_y;
  assign addr_o = addr_q;
endmodule

// File: rtl/cpp_cursor_overlay.sv
module cpp_cursor_overlay #(
  parameter int COORD_W    = 12,
  parameter int CURSOR_DIM = 64,
  localparam int CUR_LOG   = $clog2(CURSOR_DIM),
  localparam int PAT_DEPTH = CURSOR_DIM * CURSOR_DIM / 8,
  localparam int PAT_AW    = $clog2(PAT_DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pat_we_i,
  input  logic [PAT_AW-1:0]    pat_addr_i,
  input  logic [15:0]          pat_data_i,
  input  logic [2*COORD_W-1:0] cur_pos_i,
  input  logic                 cur_off_i,
  input  logic [COORD_W-1:0]   x_i,
  input  logic [COORD_W-1:0]   y_i,
  output logic [1:0]           code_o
);
  logic [15:0]        pat_q [PAT_DEPTH];
  logic [COORD_W-1:0] cx, cy, dx, dy;
  logic               in_x, in_y;
  logic [PAT_AW-1:0]  widx;
  logic [15:0]        word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAT_DEPTH; i++) pat_q[i] <= '0;
    end else if (pat_we_i) begin
      pat_q[pat_addr_i] <= pat_data_i;
    end
  end

  assign cx   = cur_pos_i[2*COORD_W-1:COORD_W];
  assign cy   = cur_pos_i[COORD_W-1:0];
  assign dx   = x_i - cx;
  assign dy   = y_i - cy;
  assign in_x = (x_i >= cx) && (dx < COORD_W'(CURSOR_DIM));
  assign in_y = (y_i >= cy) && (dy < COORD_W'(CURSOR_DIM));
  assign widx = {dy[CUR_LOG-1:0], dx[CUR_LOG-1:3]};
  assign word = pat_q[widx];

  always_comb begin
    code_o = 2'd0;
    if (!cur_off_i && in_x && in_y) code_o = word[{dx[2:0], 1'b0} +: 2];
  end
endmodule

// File: rtl/cpp_color_lookup.sv
module cpp_color_lookup
  import cpp_pkg::*;
#(
  parameter int INDEX_W = 8,
  localparam int PAL_N  = 1 << INDEX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pal_we_i,
  input  logic [INDEX_W-1:0] pal_addr_i,
  input  rgb_t               pal_data_i,
  input  logic               cpal_we_i,
  input  logic [1:0]         cpal_sel_i,
  input  rgb_t               cpal_data_i,
  input  logic               ready_i,
  input  logic               blank_i,
  input  logic [2:0]         depth_i,
  input  stage_t             stg_i,
  input  logic [INDEX_W-1:0] fb_data_i,
  output logic               valid_o,
  output rgb_t               rgb_o,
  output logic               eol_o,
  output logic               eof_o
);
  rgb_t pal_q [PAL_N];
  rgb_t cpal_q [4];
  rgb_t color;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAL_N; i++) pal_q[i] <= '0;
    end else if (pal_we_i) begin
      pal_q[pal_addr_i] <= pal_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) cpal_q[i] <= '0;
    end else if (cpal_we_i && cpal_sel_i != 2'd3) begin
      cpal_q[cpal_sel_i] <= cpal_data_i;
    end
  end

  always_comb begin
    if (blank_i || depth_i != DEPTH_8BPP) color = '0;
    else if (stg_i.ccode != 2'd0)        color = cpal_q[stg_i.ccode - 2'd1];
    else                                 color = pal_q[fb_data_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rgb_o   <= '0;
      eol_o   <= 1'b0;
      eof_o   <= 1'b0;
    end else if (ready_i) begin
      valid_o <= stg_i.valid;
      rgb_o   <= stg_i.valid ? color : '0;
      eol_o   <= stg_i.valid && stg_i.eol;
      eof_o   <= stg_i.valid && stg_i.eof;
    end
  end
endmodule

// File: rtl/cursor_pixel_pipe.sv
module cursor_pixel_pipe
  import cpp_pkg::*;
#(
  parameter int COORD_W    = 12,
  parameter int ADDR_W     = 23,
  parameter int INDEX_W    = 8,
  parameter int CURSOR_DIM = 64,
  localparam int PAT_AW    = $clog2(CURSOR_DIM * CURSOR_DIM / 8)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sof_i,
  input  logic                 ready_i,
  input  logic [COORD_W-1:0]   width_i,
  input  logic [COORD_W-1:0]   height_i,
  input  logic [ADDR_W-1:0]    top_i,
  input  logic [2*COORD_W-1:0] cur_pos_i,
  input  logic                 cur_off_i,
  input  logic                 blank_i,
  input  logic [2:0]           depth_i,
  input  logic                 pal_we_i,
  input  logic [INDEX_W-1:0]   pal_addr_i,
  input  logic [23:0]          pal_data_i,
  input  logic                 cpal_we_i,
  input  logic [1:0]           cpal_sel_i,
  input  logic [23:0]          cpal_data_i,
  input  logic                 pat_we_i,
  input  logic [PAT_AW-1:0]    pat_addr_i,
  input  logic [15:0]          pat_data_i,
  input  logic                 irq_clr_i,
  input  logic [INDEX_W-1:0]   fb_data_i,
  output logic                 fb_rd_o,
  output logic [ADDR_W-1:0]    fb_addr_o,
  output logic                 pix_valid_o,
  output logic [23:0]          pix_rgb_o,
  output logic                 pix_eol_o,
  output logic                 pix_eof_o,
  output logic                 irq_o
);
  logic               issue, eol, eof;
  logic [COORD_W-1:0] x, y;
  logic [1:0]         ccode;
  stage_t             stg_q;
  logic               irq_q;

  cpp_raster_scan #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sof_i    (sof_i),
    .ready_i  (ready_i),
    .width_i  (width_i),
    .height_i (height_i),
    .top_i    (top_i),
    .issue_o  (issue),
    .x_o      (x),
    .y_o      (y),
    .eol_o    (eol),
    .eof_o    (eof),
    .addr_o   (fb_addr_o)
  );

  cpp_cursor_overlay #(.COORD_W(COORD_W), .CURSOR_DIM(CURSOR_DIM)) u_cursor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pat_we_i   (pat_we_i),
    .pat_addr_i (pat_addr_i),
    .pat_data_i (pat_data_i),
    .cur_pos_i  (cur_pos_i),
    .cur_off_i  (cur_off_i),
    .x_i        (x),
    .y_i        (y),
    .code_o     (ccode)
  );

  // stage A: aligned with the frame-memory read data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else if (ready_i) begin
      stg_q.valid <= issue;
      stg_q.eol   <= eol;
      stg_q.eof   <= eof;
      stg_q.ccode <= ccode;
    end
  end

  cpp_color_lookup #(.INDEX_W(INDEX_W)) u_color (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pal_we_i    (pal_we_i),
    .pal_addr_i  (pal_addr_i),
    .pal_data_i  (pal_data_i),
    .cpal_we_i   (cpal_we_i),
    .cpal_sel_i  (cpal_sel_i),
    .cpal_data_i (cpal_data_i),
    .ready_i     (ready_i),
    .blank_i     (blank_i),
    .depth_i     (depth_i),
    .stg_i       (stg_q),
    .fb_data_i   (fb_data_i),
    .valid_o     (pix_valid_o),
    .rgb_o       (pix_rgb_o),
    .eol_o       (pix_eol_o),
    .eof_o       (pix_eof_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       irq_q <= 1'b0;
    else if (ready_i && pix_valid_o && pix_eof_o)      irq_q <= 1'b1;
    else if (irq_clr_i)                                irq_q <= 1'b0;
  end

  assign fb_rd_o = issue;
  assign irq_o   = irq_q;
endmodule

// File: rtl/cpp_checker.sv
module cpp_checker #(
  parameter int COORD_W    = 12,
  parameter int ADDR_W     = 23,
  parameter int INDEX_W    = 8,
  parameter int CURSOR_DIM = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ready_i,
  input logic        blank_i,
  input logic [2:0]  depth_i,
  input logic        irq_clr_i,
  input logic        fb_rd_o,
  input logic        pix_valid_o,
  input logic [23:0] pix_rgb_o,
  input logic        pix_eol_o,
  input logic        pix_eof_o,
  input logic        irq_o
);
  AST_RD_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_rd_o |-> ready_i); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(pix_valid_o) && $stable(pix_rgb_o) &&
                 $stable(pix_eol_o) && $stable(pix_eof_o)); // R2

  AST_EOF_WITH_EOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_eof_o |-> pix_eol_o && pix_valid_o); // R3

  AST_BLANK_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && blank_i |=> pix_rgb_o == 24'd0); // R8

  AST_DEPTH_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && depth_i != 3'd3 |=> pix_rgb_o == 24'd0); // R9

  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && pix_valid_o && pix_eof_o |=> irq_o); // R11

  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && !(ready_i && pix_valid_o && pix_eof_o) |=> !irq_o); // R11

  AST_IDLE_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> pix_rgb_o == 24'd0); // R12
endmodule

bind cursor_pixel_pipe cpp_checker #(
  .COORD_W(COORD_W), .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .CURSOR_DIM(CURSOR_DIM)
) u_cpp_checker (.*);

// File: tb/tb_cursor_pixel_pipe.sv
`timescale 1ns/1ps
module tb_cursor_pixel_pipe;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        sof_i = 0;
  logic        ready_i = 1;
  logic [11:0] width_i = 0, height_i = 0;
  logic [22:0] top_i = 0;
  logic [23:0] cur_pos_i = 0;
  logic        cur_off_i = 0, blank_i = 0;
  logic [2:0]  depth_i = 3;
  logic        pal_we_i = 0;
  logic [7:0]  pal_addr_i = 0;
  logic [23:0] pal_data_i = 0;
  logic        cpal_we_i = 0;
  logic [1:0]  cpal_sel_i = 0;
  logic [23:0] cpal_data_i = 0;
  logic        pat_we_i = 0;
  logic [8:0]  pat_addr_i = 0;
  logic [15:0] pat_data_i = 0;
  logic        irq_clr_i = 0;
  logic [7:0]  fb_data_i = 0;
  logic        fb_rd_o;
  logic [22:0] fb_addr_o;
  logic        pix_valid_o;
  logic [23:0] pix_rgb_o;
  logic        pix_eol_o, pix_eof_o, irq_o;

  cursor_pixel_pipe dut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit stall_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  // frame configuration mirrored for expectation
  int W, H, TOP, CX, CY;
  bit COFF, BLANK;
  int DEPTH;
  int k = 0;
  bit mon_en = 0;
  bit prev_stall = 0;
  logic pv, pe, pf;
  logic [23:0] prgb;

  function automatic logic [7:0] memf(logic [22:0] a);
    return 8'(a * 13) ^ 8'(a >> 9);
  endfunction
  function automatic logic [23:0] palf(int i);
    return {8'(i), 8'(i * 3 + 1), 8'(255 - i)};
  endfunction
  function automatic logic [23:0] cpalf(int j);
    return {8'(40 * j + 17), 8'(200 - j * 50), 8'(j * 90 + 5)};
  endfunction
  function automatic logic [15:0] patf(int w);
    return 16'(w * 40503 + 4660);
  endfunction

  function automatic logic [23:0] exp_rgb(int x, int y);
    int code, dx, dy;
    if (BLANK || DEPTH != 3) return 24'd0;
    code = 0;
    if (!COFF && x >= CX && x < CX + 64 && y >= CY && y < CY + 64) begin
      dx = x - CX;
      dy = y - CY;
      code = int'((patf(dy * 8 + dx / 8) >> ((dx % 8) * 2)) & 16'd3);
    end
    if (code != 0) return cpalf(code - 1);
    return palf(int'(memf(23'(TOP + y * W + x))));
  endfunction

  // frame memory: one cycle read latency
  always @(posedge clk_i) if (fb_rd_o) fb_data_i <= memf(fb_addr_o);

  always @(posedge clk_i) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ready_i = stall_en ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  task automatic fail_msg(string req, string what, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) fail_msg(req, what, act, exp);
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (mon_en) begin
      if (prev_stall) begin
        // R2 outputs hold across a stalled edge
        check(pix_valid_o == pv && pix_rgb_o == prgb && pix_eol_o == pe && pix_eof_o == pf,
              "R2", "stall hold rgb", pix_rgb_o, prgb);
      end
      if (pix_valid_o && ready_i) begin
        if (k >= W * H) begin
          check(0, "R3", "extra pixel", k, W * H);
        end else begin
          int x, y;
          x = k % W;
          y = k / W;
          check(pix_rgb_o == exp_rgb(x, y), "R1 R4 R5 R6 R7 R8 R9", "pixel rgb",
                pix_rgb_o, exp_rgb(x, y));
          check(pix_eol_o == (x == W - 1) && pix_eof_o == (k == W * H - 1), "R3",
                "eol/eof", {pix_eol_o, pix_eof_o}, {(x == W - 1), (k == W * H - 1)});
        end
        k++;
      end
      prev_stall = pix_valid_o && !ready_i;
      pv = pix_valid_o; prgb = pix_rgb_o; pe = pix_eol_o; pf = pix_eof_o;
    end
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired: actual=%0d expected<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic pulse_sof();
    @(posedge clk_i); #1 sof_i = 1;
    @(posedge clk_i); #1 sof_i = 0;
  endtask

  task automatic run_frame(int w, int h, int top, int cx, int cy, bit coff, bit blank,
                           int depth, bit stall, bit lat_check);
    W = w; H = h; TOP = top; CX = cx; CY = cy; COFF = coff; BLANK = blank; DEPTH = depth;
    width_i = 12'(w); height_i = 12'(h); top_i = 23'(top);
    cur_pos_i = {12'(cx), 12'(cy)}; cur_off_i = coff; blank_i = blank; depth_i = 3'(depth);
    stall_en = stall;
    repeat (3) @(posedge clk_i);
    k = 0;
    prev_stall = 0;
    mon_en = 1;
    if (lat_check) begin
      @(posedge clk_i); #1 sof_i = 1;
      @(posedge clk_i); #1 sof_i = 0;   // edge e0 sampled sof
      @(negedge clk_i);
      check(!pix_valid_o, "R2", "valid after e0", pix_valid_o, 0);
      @(negedge clk_i);
      check(!pix_valid_o, "R2", "valid after e1", pix_valid_o, 0);
      @(negedge clk_i);
      check(pix_valid_o, "R2", "valid after e2", pix_valid_o, 1);
    end else begin
      pulse_sof();
    end
    while (k < W * H) @(negedge clk_i);
    stall_en = 0;
    repeat (2) @(negedge clk_i);
    mon_en = 0;
    check(irq_o == 1'b1, "R11", "irq after frame", irq_o, 1);
    check(!pix_valid_o && pix_rgb_o == 0, "R12", "idle rgb", pix_rgb_o, 0);
    @(posedge clk_i); #1 irq_clr_i = 1;
    @(posedge clk_i); #1 irq_clr_i = 0;
    @(negedge clk_i);
    check(irq_o == 1'b0, "R11", "irq cleared", irq_o, 0);
  endtask

  task automatic zero_dim(int w, int h);
    bit bad = 0;
    width_i = 12'(w); height_i = 12'(h);
    pulse_sof();
    repeat (20) begin
      @(negedge clk_i);
      if (fb_rd_o || pix_valid_o) bad = 1;
    end
    check(!bad, "R10", "activity with zero dimension", bad, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    check(!pix_valid_o && pix_rgb_o == 0 && !irq_o && !fb_rd_o && !pix_eol_o && !pix_eof_o,
          "R12", "reset state", {pix_valid_o, irq_o, fb_rd_o}, 0);

    // load tables
    for (int i = 0; i < 256; i++) begin
      @(posedge clk_i); #1 pal_we_i = 1; pal_addr_i = 8'(i); pal_data_i = palf(i);
    end
    @(posedge clk_i); #1 pal_we_i = 0;
    for (int j = 0; j < 3; j++) begin
      @(posedge clk_i); #1 cpal_we_i = 1; cpal_sel_i = 2'(j); cpal_data_i = cpalf(j);
    end
    // select 3 must be dropped (R6)
    @(posedge clk_i); #1 cpal_sel_i = 2'd3; cpal_data_i = 24'hFFFFFF;
    @(posedge clk_i); #1 cpal_we_i = 0;
    for (int w = 0; w < 512; w++) begin
      @(posedge clk_i); #1 pat_we_i = 1; pat_addr_i = 9'(w); pat_data_i = patf(w);
    end
    @(posedge clk_i); #1 pat_we_i = 0;

    run_frame(80, 70, 'h1234, 5, 3, 0, 0, 3, 0, 1);        // R2 latency, R4 R5 R6
    run_frame(80, 70, 'h7fff00, 60, 60, 0, 0, 3, 1, 0);    // stalls, address wrap, cursor clipped
    run_frame(80, 70, 'h40, 5, 3, 1, 0, 3, 0, 0);          // R7 cursor disabled
    run_frame(80, 70, 'h40, 5, 3, 0, 1, 3, 1, 0);          // R8 blank
    run_frame(80, 70, 'h40, 5, 3, 0, 0, 2, 0, 0);          // R9 depth code 2
    run_frame(16, 4, 'h99, 0, 0, 0, 0, 3, 1, 0);           // small frame, cursor at origin
    zero_dim(0, 10);                                       // R10
    zero_dim(10, 0);                                       // R10

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule